// File: doc/BRIEF.md
# CAN Fault Confinement Counters with Bus-Off Recovery

This block keeps the two error tallies of a CAN node. One counts transmit-side faults and the other counts receive-side faults. From these tallies it derives three states: a warning level, a passive level and bus-off. The frame engine reports each finished frame as a single-cycle pulse. A failed transfer raises the pulse for its own direction and moves that tally up. A clean transfer lowers it. Each flag is held in a register. The block also emits one-cycle change pulses, which the interrupt logic uses to raise status and error requests.

When the transmit tally goes past 255, the node enters bus-off. It sets its own halt bit and ignores all frame outcomes from then on. Software begins recovery by writing zero to the halt bit. The block then watches the sampled receive line at each bit strobe and counts runs of recessive bits. Every finished run writes the bit-0 error code into the last-error-code field and raises a status event. Once enough runs have completed, the node is back in step with the bus: bus-off clears and both tallies return to zero.

Top module: `can_fault_confine`

## Requirements
- R1: After reset, every flag and pulse output is 0, the halt bit is 0, and the last-error-code field is 0.
- R2: A transmit error pulse adds 1 to the transmit tally and a receive error pulse adds 1 to the receive tally. The warning flag is 1 whenever either tally is 96 or higher. The flag updates on the clock edge that samples the pulse.
- R3: Each time the warning flag changes value, warn_chg_o is 1 for exactly one cycle, on the same edge as the change.
- R4: A transmit success pulse subtracts 1 from the transmit tally and a receive success pulse subtracts 1 from the receive tally. A tally already at 0 stays at 0.
- R5: err_passive_o is 1 whenever either tally is 128 or higher. It stays 1 throughout bus-off.
- R6: When the node is passive, a receive error pulse leaves the receive tally unchanged, whichever tally caused the passive state.
- R7: A transmit error that lifts the transmit tally from 255 to 256 sets busoff_o and the halt bit together, and pulses boff_chg_o.
- R8: While the halt bit is 1, no recessive run is counted, no status event is raised, and bus-off cannot clear.
- R9: During recovery (bus-off set, halt bit 0), a bit strobe with rx_bit_i=1 extends the current run and a strobe with rx_bit_i=0 restarts it. When a run reaches 11 recessive strobes, stat_evt_o pulses and lec_o becomes 5, the bit-0 code.
- R10: When the 128th run completes, busoff_o falls and boff_chg_o pulses. Both tallies become 0, so warning and passive drop on that same edge.
- R11: While the halt bit is 1 and bus-off is clear, all error and success pulses are ignored. Software sets and clears the halt bit by writing init_wdata_i with init_wr_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_i | input | 1 | One-cycle pulse: transmit frame failed |
| rx_err_i | input | 1 | One-cycle pulse: receive frame failed |
| tx_ok_i | input | 1 | One-cycle pulse: transmit frame succeeded |
| rx_ok_i | input | 1 | One-cycle pulse: receive frame succeeded |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| bit_stb_i | input | 1 | One pulse per bit time, qualifies rx_bit_i |
| init_wr_i | input | 1 | Software write strobe for the halt bit |
| init_wdata_i | input | 1 | Value written to the halt bit |
| warn_o | output | 1 | Warning level reached |
| err_passive_o | output | 1 | Passive level reached |
| busoff_o | output | 1 | Node is bus-off |
| init_o | output | 1 | Halt bit |
| lec_o | output | 3 | Last error code |
| warn_chg_o | output | 1 | Pulse on any change of warn_o |
| boff_chg_o | output | 1 | Pulse on any change of busoff_o |
| stat_evt_o | output | 1 | Pulse after each completed recessive run |

## Verification
The assertions assume that the frame engine never raises an error pulse and a success pulse for the same direction in one cycle. They also assume that bit strobes carry one sampled bit at a time. The stimulus follows both rules: each task drives exactly one kind of frame outcome or one bit per cycle. Every input changes one time unit after a rising edge, so each edge sees clean, settled values.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [2:0] {
    LEC_NONE = 3'd0,
    LEC_BIT0 = 3'd5
  } lec_e;

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int NDIR   = 2;

endpackage

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);

  always_comb begin
    cnt_nxt = cnt;
    if (clr)
      cnt_nxt = '0;
    else if (inc)
      cnt_nxt = cnt + W'(1);
    else if (dec && cnt != '0)
      cnt_nxt = cnt - W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
  parameter int BITS = 11,
  parameter int SEQS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic stb,
  input  logic rx_bit,
  output logic seq_hit,
  output logic done
);

  localparam int BW = $clog2(BITS);
  localparam int SW = (SEQS > 1) ? $clog2(SEQS) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS - 1);
  localparam logic [SW-1:0] SEQ_LAST = SW'(SEQS - 1);

  logic [BW-1:0] bit_cnt;
  logic [SW-1:0] seq_cnt;

  assign seq_hit = en && stb && rx_bit && (bit_cnt == BIT_LAST);
  assign done    = seq_hit && (seq_cnt == SEQ_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bit_cnt <= '0;
      seq_cnt <= '0;
    end else if (stb) begin
      if (!rx_bit) begin
        bit_cnt <= '0;
      end else if (bit_cnt == BIT_LAST) begin
        bit_cnt <= '0;
        seq_cnt <= done ? '0 : seq_cnt + SW'(1);
      end else begin
        bit_cnt <= bit_cnt + BW'(1);
      end
    end
  end

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 255,
  parameter int REC_BITS = 11,
  parameter int REC_SEQS = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_err_i,
  input  logic       rx_err_i,
  input  logic       tx_ok_i,
  input  logic       rx_ok_i,
  input  logic       rx_bit_i,
  input  logic       bit_stb_i,
  input  logic       init_wr_i,
  input  logic       init_wdata_i,
  output logic       warn_o,
  output logic       err_passive_o,
  output logic       busoff_o,
  output logic       init_o,
  output logic [2:0] lec_o,
  output logic       warn_chg_o,
  output logic       boff_chg_o,
  output logic       stat_evt_o
);

  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);
  localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BOFF_LIM);

  logic [CNT_W-1:0] cnt [NDIR];
  logic [CNT_W-1:0] nxt [NDIR];
  logic [NDIR-1:0]  inc, dec, err_in, ok_in;
  logic active, passive_now, rec_en, seq_hit, rec_done, enter_boff;
  logic warn_d, pass_d;

  assign active      = !init_o && !busoff_o;
  assign passive_now = (cnt[DIR_TX] >= PASS_V) || (cnt[DIR_RX] >= PASS_V);
  assign rec_en      = busoff_o && !init_o;

  assign err_in = {rx_err_i, tx_err_i};
  assign ok_in  = {rx_ok_i,  tx_ok_i};

  // transmit side always counts up; receive side freezes once passive
  assign inc[DIR_TX] = active && err_in[DIR_TX];
  assign inc[DIR_RX] = active && err_in[DIR_RX] && !passive_now;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    assign dec[g] = active && ok_in[g] && !err_in[g];
    can_fc_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .inc     (inc[g]),
      .dec     (dec[g]),
      .clr     (rec_done),
      .cnt     (cnt[g]),
      .cnt_nxt (nxt[g])
    );
  end

  can_fc_recovery #(.BITS(REC_BITS), .SEQS(REC_SEQS)) u_rec (
    .clk     (clk),
    .rst     (rst),
    .en      (rec_en),
    .stb     (bit_stb_i),
    .rx_bit  (rx_bit_i),
    .seq_hit (seq_hit),
    .done    (rec_done)
  );

  assign enter_boff = !busoff_o && (nxt[DIR_TX] > BOFF_V);
  assign warn_d = (nxt[DIR_TX] >= WARN_V) || (nxt[DIR_RX] >= WARN_V);
  assign pass_d = (nxt[DIR_TX] >= PASS_V) || (nxt[DIR_RX] >= PASS_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_o        <= 1'b0;
      err_passive_o <= 1'b0;
      busoff_o      <= 1'b0;
      init_o        <= 1'b0;
      lec_o         <= LEC_NONE;
      warn_chg_o    <= 1'b0;
      boff_chg_o    <= 1'b0;
      stat_evt_o    <= 1'b0;
    end else begin
      warn_o        <= warn_d;
      warn_chg_o    <= warn_d != warn_o;
      err_passive_o <= pass_d;
      boff_chg_o    <= enter_boff || rec_done;
      stat_evt_o    <= seq_hit;
      if (enter_boff)    busoff_o <= 1'b1;
      else if (rec_done) busoff_o <= 1'b0;
      if (enter_boff)     init_o <= 1'b1;
      else if (init_wr_i) init_o <= init_wdata_i;
      if (seq_hit) lec_o <= LEC_BIT0;
    end
  end

endmodule

// File: rtl/can_fault_confine_chk.sv
module can_fault_confine_chk (
  input logic       clk,
  input logic       rst,
  input logic       warn_o,
  input logic       err_passive_o,
  input logic       busoff_o,
  input logic       init_o,
  input logic [2:0] lec_o,
  input logic       warn_chg_o,
  input logic       boff_chg_o,
  input logic       stat_evt_o
);

  // R3
  warn_chg_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    warn_chg_o == (warn_o != $past(warn_o)));

  // R7
  boff_sets_init_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busoff_o) |-> (init_o && boff_chg_o));

  // R5
  boff_passive_chk: assert property (@(posedge clk) disable iff (rst)
    busoff_o |-> err_passive_o);

  // R9
  stat_lec_chk: assert property (@(posedge clk) disable iff (rst)
    stat_evt_o |-> (lec_o == 3'd5));

  // R10
  boff_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busoff_o) |-> (!warn_o && !err_passive_o && stat_evt_o && boff_chg_o));

  // R8
  halt_holds_boff_chk: assert property (@(posedge clk) disable iff (rst)
    (busoff_o && init_o) |=> (busoff_o && !stat_evt_o));

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (init_o && !busoff_o) |=> (!warn_chg_o && $stable(err_passive_o)));

endmodule

bind can_fault_confine can_fault_confine_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .warn_o        (warn_o),
  .err_passive_o (err_passive_o),
  .busoff_o      (busoff_o),
  .init_o        (init_o),
  .lec_o         (lec_o),
  .warn_chg_o    (warn_chg_o),
  .boff_chg_o    (boff_chg_o),
  .stat_evt_o    (stat_evt_o)
);

// File: tb/can_fault_confine_test.sv
module can_fault_confine_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic tx_err_i = 0, rx_err_i = 0, tx_ok_i = 0, rx_ok_i = 0;
  logic rx_bit_i = 0, bit_stb_i = 0, init_wr_i = 0, init_wdata_i = 0;
  logic warn_o, err_passive_o, busoff_o, init_o, warn_chg_o, boff_chg_o, stat_evt_o;
  logic [2:0] lec_o;

  int total = 0;
  int bad = 0;
  int nevt = 0;

  can_fault_confine uut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit te, bit re, bit to, bit ro);
    tx_err_i = te; rx_err_i = re; tx_ok_i = to; rx_ok_i = ro;
    @(posedge clk); #1;
    tx_err_i = 0; rx_err_i = 0; tx_ok_i = 0; rx_ok_i = 0;
  endtask

  task automatic rep(int n, bit te, bit re, bit to, bit ro);
    for (int i = 0; i < n; i++) step(te, re, to, ro);
  endtask

  task automatic rbit(bit b);
    bit_stb_i = 1; rx_bit_i = b;
    @(posedge clk); #1;
    bit_stb_i = 0; rx_bit_i = 0;
    if (stat_evt_o) nevt++;
  endtask

  task automatic rbits(int n, bit b);
    for (int i = 0; i < n; i++) rbit(b);
  endtask

  task automatic set_init(bit v);
    init_wr_i = 1; init_wdata_i = v;
    @(posedge clk); #1;
    init_wr_i = 0; init_wdata_i = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1 warn", warn_o, 0);
    chk("R1 passive", err_passive_o, 0);
    chk("R1 busoff", busoff_o, 0);
    chk("R1 init", init_o, 0);
    chk("R1 lec", lec_o, 0);
    chk("R1 pulses", {warn_chg_o, boff_chg_o, stat_evt_o}, 0);

    // R2 warning threshold on transmit side
    rep(95, 1, 0, 0, 0);
    chk("R2 tec95 warn", warn_o, 0);
    step(1, 0, 0, 0);
    chk("R2 tec96 warn", warn_o, 1);
    chk("R3 rise pulse", warn_chg_o, 1);
    step(0, 0, 0, 0);
    chk("R3 pulse one cycle", warn_chg_o, 0);
    // R4 decrement
    step(0, 0, 1, 0);
    chk("R4 tec95 warn", warn_o, 0);
    chk("R3 fall pulse", warn_chg_o, 1);
    // R5 passive at 128
    rep(32, 1, 0, 0, 0);
    chk("R5 tec127 passive", err_passive_o, 0);
    step(1, 0, 0, 0);
    chk("R5 tec128 passive", err_passive_o, 1);
    // R6 receive frozen while passive from transmit side
    rep(200, 0, 1, 0, 0);
    step(0, 0, 1, 0);
    chk("R5 tec127 not passive", err_passive_o, 0);
    rep(127, 0, 0, 1, 0);
    chk("R6 rec stayed 0", warn_o, 0);
    // R6 receive saturates at 128
    rep(150, 0, 1, 0, 0);
    chk("R5 rec128 passive", err_passive_o, 1);
    rep(32, 0, 0, 0, 1);
    chk("R6 rec96 warn", warn_o, 1);
    chk("R5 rec96 passive", err_passive_o, 0);
    step(0, 0, 0, 1);
    chk("R6 rec95 warn", warn_o, 0);
    // R4 floor at zero, receive side
    rep(100, 0, 0, 0, 1);
    rep(95, 0, 1, 0, 0);
    chk("R4 floor rec95 warn", warn_o, 0);
    step(0, 1, 0, 0);
    chk("R2 rec96 warn", warn_o, 1);
    rep(96, 0, 0, 0, 1);
    chk("R4 rec0 warn", warn_o, 0);

    // R7 bus-off entry
    rep(255, 1, 0, 0, 0);
    chk("R7 tec255 busoff", busoff_o, 0);
    step(1, 0, 0, 0);
    chk("R7 busoff", busoff_o, 1);
    chk("R7 init", init_o, 1);
    chk("R7 chg pulse", boff_chg_o, 1);
    step(0, 0, 0, 0);
    chk("R7 chg one cycle", boff_chg_o, 0);

    // R8 halt held: no recovery
    nevt = 0;
    rep(10, 0, 0, 1, 1);
    rbits(300, 1);
    chk("R8 no events", nevt, 0);
    chk("R8 busoff held", busoff_o, 1);

    // R9 recovery runs
    set_init(0);
    chk("R11 init cleared", init_o, 0);
    chk("R9 busoff still", busoff_o, 1);
    rbits(10, 1);
    rbit(0);
    rbits(10, 1);
    chk("R9 dominant restarts", nevt, 0);
    rbit(1);
    chk("R9 first run event", stat_evt_o, 1);
    chk("R9 lec bit0", lec_o, 5);
    rbit(0);
    chk("R9 event one cycle", stat_evt_o, 0);
    for (int s = 0; s < 126; s++) rbits(11, 1);
    chk("R9 127 runs counted", nevt, 127);
    chk("R10 busoff before last", busoff_o, 1);
    rbits(11, 1);
    chk("R10 busoff cleared", busoff_o, 0);
    chk("R10 chg pulse", boff_chg_o, 1);
    chk("R10 warn cleared", warn_o, 0);
    chk("R10 passive cleared", err_passive_o, 0);
    chk("R10 last event", stat_evt_o, 1);
    // R10 counters restarted at zero
    rep(95, 1, 0, 0, 0);
    chk("R10 tec95 warn", warn_o, 0);
    step(1, 0, 0, 0);
    chk("R10 tec96 warn", warn_o, 1);

    // R11 pulses ignored while halted
    set_init(1);
    chk("R11 init set", init_o, 1);
    rep(60, 0, 0, 1, 0);
    rep(200, 1, 1, 0, 0);
    nevt = 0;
    rbits(30, 1);
    chk("R11 no run events", nevt, 0);
    set_init(0);
    step(0, 0, 0, 0);
    chk("R11 warn kept", warn_o, 1);
    chk("R11 busoff kept", busoff_o, 0);
    chk("R11 passive kept", err_passive_o, 0);
    step(0, 0, 1, 0);
    chk("R11 live again", warn_o, 0);

    finish_run();
  end

endmodule